// File: doc/BRIEF.md
# Alternating-Polarity Stepping Coil Pulse Generator

This block drives the single coil of the stepping motor in an analogue quartz timepiece from a 32.768 kHz clock. A binary divider counts out one second of clock cycles. On each one-second boundary the block drives one coil terminal low for a fixed 256-cycle window, which is 7.8125 ms. The terminal chosen alternates from step to step, so the coil current reverses on every step. Between steps both terminals sit high, which shorts the coil across the supply rail so it cannot build up back-EMF. The two outputs feed an external push-pull stage.

Two inputs can stop the stepping. The asynchronous power-on reset puts everything into a known state. A crown push-button input is synchronised and debounced, and while it is held down the divider is kept cleared and the coil stays idle. A test-mode input shortens the step period so that several steps can be watched in a short simulation.

Top module: `coil_step_driver`

## Requirements
- R1: While `rst_n` is low, and after its release until the first step, both `coil_a` and `coil_b` are 1 and no pulse is produced.
- R2: With `fast_mode` at 0, the first pulse starts on the 32768th rising clock edge after the release from reset or hold. Further pulses start every 32768 cycles after that. Nothing happens at the half-second point.
- R3: Every complete pulse holds its active terminal low for exactly 256 clock cycles. The terminal then returns to 1.
- R4: Successive pulses alternate between the two terminals. The first pulse after reset or after a crown hold drives `coil_a` low with `coil_b` high. The next pulse drives `coil_b` low with `coil_a` high, and so on.
- R5: `coil_a` and `coil_b` are never both 0 in the same cycle.
- R6: A level on `crown_in` (1 = pressed) that lasts fewer than 66 consecutive cycles is ignored. The stepping schedule and the polarity sequence carry on unchanged.
- R7: A press that holds `crown_in` at 1 is accepted on the 68th rising edge after the input changes: 2 edges for the synchroniser and 66 stable cycles. While the press is accepted, both outputs are 1 at once, any running pulse is abandoned, the divider is cleared and the polarity returns to `coil_a`. A release is accepted with the same 68-edge latency. The first pulse then starts one full step period after the accepted release.
- R8: With `fast_mode` at 1, the top 6 divider stages are bypassed. The step period is 512 cycles, and pulse width and polarity behave as in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| crown_in | input | 1 | Raw crown push-button level, 1 = pressed |
| fast_mode | input | 1 | Test mode, 1 = 512-cycle step period |
| coil_a | output | 1 | Coil terminal A logic level, 0 = driven low during a pulse |
| coil_b | output | 1 | Coil terminal B logic level, 0 = driven low during a pulse |

## Verification
The hardest case to reach from the ports is a crown press that is accepted while a pulse is half finished. The test has to abandon the pulse, clear the divider and reset the polarity, and then it has to confirm that the first step after release goes to terminal A exactly one period after the accepted release. The stimulus runs in fast mode and lets four steps finish first, so that the polarity has moved away from its reset value. It then applies a 40-cycle glitch that must change nothing. After that it presses the crown at a fixed offset inside the fifth pulse and releases it later. Expected edges are counted from the input changes plus the 68-edge acceptance latency.

// File: rtl/coil_step_pkg.sv
package coil_step_pkg;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } coil_side_e;

  function automatic coil_side_e other_side(input coil_side_e s);
    return (s == SIDE_A) ? SIDE_B : SIDE_A;
  endfunction

endpackage

// File: rtl/crown_filter.sv
module crown_filter #(
  parameter int unsigned STABLE_CYCLES = 66
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level_out
);
  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b00;
      run_q   <= '0;
      level_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_in};
      if (sync_q[1] != level_q) begin
        if (run_q == LAST) begin
          level_q <= sync_q[1];
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign level_out = level_q;
endmodule

// File: rtl/step_divider.sv
module step_divider #(
  parameter int unsigned STAGES    = 15,
  parameter int unsigned FAST_SKIP = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic fast,
  output logic tick
);
  localparam int unsigned LOW = STAGES - FAST_SKIP;

  logic [STAGES-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end

  generate
    if (FAST_SKIP == 0) begin : g_no_fast
      assign tick = (&count_q) & ~clear;
    end else begin : g_fast
      logic full_tc;
      logic low_tc;
      assign full_tc = &count_q;
      assign low_tc  = &count_q[LOW-1:0];
      assign tick    = (fast ? low_tc : full_tc) & ~clear;
    end
  endgenerate
endmodule

// File: rtl/pulse_shaper.sv
module pulse_shaper
  import coil_step_pkg::*;
#(
  parameter int unsigned WIDTH_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       tick,
  output logic       active,
  output coil_side_e side
);
  localparam int unsigned WW = $clog2(WIDTH_CYCLES);
  localparam logic [WW-1:0] WLAST = WW'(WIDTH_CYCLES - 1);

  logic [WW-1:0] width_q;
  logic          active_q;
  coil_side_e    cur_q;
  coil_side_e    next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= '0;
      active_q <= 1'b0;
      cur_q    <= SIDE_A;
      next_q   <= SIDE_A;
    end else if (clear) begin
      width_q  <= '0;
      active_q <= 1'b0;
      cur_q    <= SIDE_A;
      next_q   <= SIDE_A;
    end else if (!active_q) begin
      if (tick) begin
        active_q <= 1'b1;
        width_q  <= '0;
        cur_q    <= next_q;
        next_q   <= other_side(next_q);
      end
    end else if (width_q == WLAST) begin
      active_q <= 1'b0;
      width_q  <= '0;
    end else begin
      width_q <= width_q + 1'b1;
    end
  end

  assign active = active_q;
  assign side   = cur_q;
endmodule

// File: rtl/coil_step_driver.sv
module coil_step_driver
  import coil_step_pkg::*;
#(
  parameter int unsigned DIV_STAGES   = 15,
  parameter int unsigned FAST_SKIP    = 6,
  parameter int unsigned PULSE_CYCLES = 256,
  parameter int unsigned CROWN_STABLE = 66
) (
  input  logic clk,
  input  logic rst_n,
  input  logic crown_in,
  input  logic fast_mode,
  output logic coil_a,
  output logic coil_b
);
  logic       held;
  logic       tick;
  logic       active;
  coil_side_e side;

  crown_filter #(.STABLE_CYCLES(CROWN_STABLE)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_in    (crown_in),
    .level_out (held)
  );

  step_divider #(.STAGES(DIV_STAGES), .FAST_SKIP(FAST_SKIP)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (held),
    .fast  (fast_mode),
    .tick  (tick)
  );

  pulse_shaper #(.WIDTH_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (held),
    .tick   (tick),
    .active (active),
    .side   (side)
  );

  // Idle level is high on both terminals; a held crown forces idle at once.
  logic drive;
  assign drive  = active & ~held;
  assign coil_a = ~(drive & (side == SIDE_A));
  assign coil_b = ~(drive & (side == SIDE_B));
endmodule

// File: rtl/coil_step_checker.sv
module coil_step_checker #(
  parameter int unsigned PULSE_CYCLES = 256
) (
  input logic clk,
  input logic rst_n,
  input logic coil_a,
  input logic coil_b,
  input logic held,
  input logic tick
);
  logic        have_last;
  logic        last_b;
  logic [31:0] low_run;
  logic        start_a;
  logic        start_b;

  assign start_a = !coil_a && coil_b && (low_run == 0);
  assign start_b = !coil_b && coil_a && (low_run == 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_b    <= 1'b0;
      low_run   <= '0;
    end else if (held) begin
      have_last <= 1'b0;
      low_run   <= '0;
    end else begin
      if (!coil_a || !coil_b) begin
        low_run <= low_run + 1;
      end else begin
        low_run <= '0;
      end
      if (start_a || start_b) begin
        have_last <= 1'b1;
        last_b    <= start_b;
      end
    end
  end

  // R5: terminals never both low
  a_r5_never_both_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(!coil_a && !coil_b));

  // R7: accepted crown press keeps the coil idle
  a_r7_idle_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (coil_a && coil_b));

  // R2: a pulse only begins right after a divider terminal count
  a_r2_start_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(coil_a) || $fell(coil_b)) |-> $past(tick));

  // R4: first step after reset/hold is A, then strictly alternating
  a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && (start_a || start_b)) |->
      (have_last ? (start_b != last_b) : start_a));

  // R3: a complete pulse lasts exactly the configured width
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && coil_a && coil_b && (low_run != 0)) |-> (low_run == PULSE_CYCLES));
endmodule

bind coil_step_driver coil_step_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .coil_a (coil_a),
  .coil_b (coil_b),
  .held   (held),
  .tick   (tick)
);

// File: tb/sim_coil_step_driver.sv
module sim_coil_step_driver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic crown_in = 1'b0;
  logic fast_mode = 1'b0;
  logic coil_a;
  logic coil_b;

  int unsigned cyc = 0;
  int checks = 0;
  int failures = 0;
  int both_low = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  coil_step_driver u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .crown_in  (crown_in),
    .fast_mode (fast_mode),
    .coil_a    (coil_a),
    .coil_b    (coil_b)
  );

  always @(negedge clk) if (rst_n && !coil_a && !coil_b) both_low++;

  // Fast-mode table: edge offset after release, expected {a,b}
  localparam int NV = 12;
  localparam int unsigned OFFS [NV] = '{1, 511, 512, 767, 768, 1023,
                                        1024, 1279, 1280, 1536, 2000, 2048};
  localparam logic [1:0] EXPV [NV] = '{2'b11, 2'b11, 2'b01, 2'b01, 2'b11, 2'b11,
                                       2'b10, 2'b10, 2'b11, 2'b01, 2'b11, 2'b10};
  localparam string TAGS [NV] = '{"R1", "R1", "R8", "R3", "R3", "R4",
                                  "R4", "R3", "R3", "R4", "R8", "R4"};

  task automatic wait_edge(input int unsigned base, input int unsigned n);
    while (cyc != base + n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [1:0] exp);
    checks++;
    if ({coil_a, coil_b} !== exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual a,b=%b expected a,b=%b",
               tag, cyc, {coil_a, coil_b}, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int unsigned base;
    int unsigned b2;
    fast_mode = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle in reset", 2'b11);
    rst_n = 1'b1;
    base = cyc;

    for (int i = 0; i < NV; i++) begin
      wait_edge(base, OFFS[i]);
      check(TAGS[i], EXPV[i]);
    end

    // R6: 40-cycle glitch must not disturb the schedule or polarity
    wait_edge(base, 2100);
    crown_in = 1'b1;
    repeat (40) @(negedge clk);
    crown_in = 1'b0;
    wait_edge(base, 2559);
    check("R6 idle before step", 2'b11);
    wait_edge(base, 2560);
    check("R6 step kept on A", 2'b01);

    // R7: press accepted mid-pulse
    wait_edge(base, 2600);
    crown_in = 1'b1;
    b2 = cyc;
    wait_edge(b2, 67);
    check("R7 pulse still running before accept", 2'b01);
    wait_edge(b2, 68);
    check("R7 abort on accept", 2'b11);
    wait_edge(b2, 700);
    check("R7 idle while held", 2'b11);
    crown_in = 1'b0;
    b2 = cyc;
    wait_edge(b2, 579);
    check("R7 idle before first step", 2'b11);
    wait_edge(b2, 580);
    check("R7 first step on A", 2'b01);
    wait_edge(b2, 835);
    check("R3 last low cycle", 2'b01);
    wait_edge(b2, 836);
    check("R3 released", 2'b11);
    wait_edge(b2, 1092);
    check("R4 second step on B", 2'b10);

    // R2: normal one-second period
    @(negedge clk);
    rst_n = 1'b0;
    fast_mode = 1'b0;
    @(negedge clk);
    check("R1 idle in reset", 2'b11);
    rst_n = 1'b1;
    base = cyc;
    wait_edge(base, 512);
    check("R2 no fast step", 2'b11);
    wait_edge(base, 16384);
    check("R2 half second idle", 2'b11);
    wait_edge(base, 32767);
    check("R2 idle before second", 2'b11);
    wait_edge(base, 32768);
    check("R2 step at one second", 2'b01);
    wait_edge(base, 33023);
    check("R3 normal width end", 2'b01);
    wait_edge(base, 33024);
    check("R3 normal release", 2'b11);

    checks++;
    if (both_low != 0) begin
      failures++;
      $display("FAIL R5 both terminals low: actual=%0d cycles expected=0", both_low);
    end
    finish_run();
  end
endmodule